// File: doc/BRIEF.md
# Serial NOR Flash Page-Program Writer

This block drives the programming side of a serial NOR flash. Software sets a 24-bit target address through three byte-wide address registers. It chooses between a whole-page mode and a one-byte mode, and starts a write by setting a trigger bit in the command register. In page mode the payload is a 256-byte page. That page is first loaded by repeated 32-bit writes to a single word port, and each word is unpacked with its least significant byte first. In one-byte mode the payload is the single byte held in the byte data register.

Each operation produces two chip-select frames on a mode-0 SPI output. The first frame is the write-enable opcode. The second is the program opcode, then the address with its most significant byte first, then the payload. Software watches the trigger bit, which clears by itself when the second frame has ended. A key register must hold a fixed value before any trigger is accepted. An optional modifier bit advances the address after each one-byte write, so a run of bytes needs no reloading of the address.

Top module: `pgm_flash_writer`

## Requirements
- R1: After reset the command view reads 0x00, chip select is high (inactive), and the serial clock and data lines are low.
- R2: Register select 1 loads address bits 7:0, select 2 loads bits 15:8 and select 3 loads bits 23:16, each from write data bits 7:0. On the wire the address goes out as bits 23:16, then 15:8, then 7:0.
- R3: Writing to select 0 with bit 4 set, while the block is idle and the key holds the correct value, sets command bit 4 (trigger) and latches bit 7 (auto-increment). Both bits read back until the operation ends, and then both clear in the same cycle. A write with bit 4 clear has no effect.
- R4: Select 7 loads the key from data bits 7:0. A trigger is accepted only while the key equals 0x30. Otherwise the command stays at 0x00 and no frame is sent.
- R5: Every accepted trigger sends a frame holding only 0x06. Chip select then goes high for at least one clock. The next frame holds 0x02, the three address bytes and the payload.
- R6: With select 6 bit 0 equal to 0 (one-byte mode), the payload is the single byte last written to select 4.
- R7: With select 6 bit 0 equal to 1 (page mode), the payload is 256 bytes. The n-th word written to select 5 provides page bytes 4n to 4n+3, with data bits 7:0 first and bits 31:24 last.
- R8: The word-port fill pointer wraps after 64 writes, so the 65th write replaces page bytes 0 to 3. The pointer returns to word 0 when a page operation completes.
- R9: After a one-byte operation that was started with bit 7 set, the address increases by one, wrapping from 0xFFFFFF to 0x000000. A page operation, or an operation started without bit 7, leaves the address unchanged.
- R10: Every register write made while the trigger bit reads 1 is ignored.
- R11: Data is shifted out MSB first at two clocks per bit. The data line changes only while the serial clock is low, and the serial clock stays low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 command, 1-3 address bytes, 4 byte data, 5 word port, 6 mode, 7 key) |
| reg_wdata | input | 32 | Register write data |
| cmd_q | output | 8 | Command view: bit 4 trigger/busy, bit 7 auto-increment |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |

## Verification
The main function is exercised in four ways. One-byte writes with distinct address bytes show whether the three address registers are ordered correctly. A page filled with bytes that all differ exposes any lane swap in the little-endian unpacking. A page loaded with 66 words checks the wrap of the fill pointer, and a refill after a completed page checks that the pointer restarts at word 0. Chained one-byte writes that cross 0xFFFFFF check the address increment and its wrap. Triggers made with a wrong key, without bit 4, or as register writes during a busy operation must leave both the wire and the following frame unchanged.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam int GO_BIT  = 4;
  localparam int INC_BIT = 7;

  typedef enum logic [2:0] {
    SEL_CMD  = 3'd0,
    SEL_A0   = 3'd1,
    SEL_A1   = 3'd2,
    SEL_A2   = 3'd3,
    SEL_BYTE = 3'd4,
    SEL_WORD = 3'd5,
    SEL_MODE = 3'd6,
    SEL_KEY  = 3'd7
  } reg_sel_t;

  typedef enum logic [2:0] {
    S_IDLE, S_WE_SEND, S_WE_WAIT, S_GAP, S_PP_SEND, S_PP_WAIT, S_FIN
  } seq_state_t;
endpackage

// File: rtl/pgm_page_buf.sv
module pgm_page_buf #(
  parameter int WORDS = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pgm_bit_shifter.sv
module pgm_bit_shifter #(
  parameter int BITS = 8,
  localparam int CW  = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [BITS-1:0] din,
  output logic            ready,
  output logic            sck,
  output logic            mosi
);
  logic            busy;
  logic [BITS-1:0] sh;
  logic [CW-1:0]   bitn;

  assign ready = !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sck  <= 1'b0;
      mosi <= 1'b0;
      sh   <= '0;
      bitn <= '0;
    end else if (!busy) begin
      if (load) begin
        busy <= 1'b1;
        sh   <= din;
        mosi <= din[BITS-1];
        bitn <= '0;
        sck  <= 1'b0;
      end
    end else if (!sck) begin
      sck <= 1'b1;
    end else begin
      sck <= 1'b0;
      if (bitn == CW'(BITS-1)) begin
        busy <= 1'b0;
      end else begin
        bitn <= bitn + 1'b1;
        sh   <= {sh[BITS-2:0], 1'b0};
        mosi <= sh[BITS-2];
      end
    end
  end
endmodule

// File: rtl/pgm_frame_seq.sv
module pgm_frame_seq
  import pgm_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  localparam int FRAME_MAX = PAGE_BYTES + 4,
  localparam int KW        = $clog2(FRAME_MAX + 1),
  localparam int BAW       = $clog2(PAGE_BYTES),
  localparam int WAW       = BAW - 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           page_mode,
  input  logic [23:0]    addr,
  input  logic [7:0]     single_byte,
  input  logic [31:0]    ram_rdata,
  output logic [WAW-1:0] ram_raddr,
  output logic           done,
  output logic           cs_n,
  output logic           sck,
  output logic           mosi
);
  seq_state_t    state;
  logic [KW-1:0] k;
  logic [KW-1:0] payload_idx;
  logic [KW-1:0] frame_last;
  logic [1:0]    lane;
  logic [7:0]    frame_byte;
  logic [7:0]    tx_byte;
  logic          sh_load;
  logic          sh_ready;

  assign payload_idx = k - KW'(4);
  assign ram_raddr   = payload_idx[BAW-1:2];
  assign lane        = payload_idx[1:0];
  assign frame_last  = page_mode ? KW'(FRAME_MAX) : KW'(5);
  assign done        = (state == S_FIN);

  always_comb begin
    case (k)
      KW'(0):  frame_byte = OP_PROG;
      KW'(1):  frame_byte = addr[23:16];
      KW'(2):  frame_byte = addr[15:8];
      KW'(3):  frame_byte = addr[7:0];
      default: frame_byte = page_mode ? ram_rdata[{lane, 3'b000} +: 8] : single_byte;
    endcase
  end

  assign tx_byte = (state == S_WE_SEND) ? OP_WREN : frame_byte;
  assign sh_load = (state == S_WE_SEND) || (state == S_PP_SEND);

  pgm_bit_shifter #(.BITS(8)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .load  (sh_load),
    .din   (tx_byte),
    .ready (sh_ready),
    .sck   (sck),
    .mosi  (mosi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cs_n  <= 1'b1;
      k     <= '0;
    end else begin
      case (state)
        S_IDLE: if (go) begin
          cs_n  <= 1'b0;
          state <= S_WE_SEND;
        end
        S_WE_SEND: state <= S_WE_WAIT;
        S_WE_WAIT: if (sh_ready) begin
          cs_n  <= 1'b1;
          state <= S_GAP;
        end
        S_GAP: begin
          cs_n  <= 1'b0;
          k     <= '0;
          state <= S_PP_SEND;
        end
        S_PP_SEND: begin
          k     <= k + 1'b1;
          state <= S_PP_WAIT;
        end
        S_PP_WAIT: if (sh_ready) begin
          if (k == frame_last) begin
            cs_n  <= 1'b1;
            state <= S_FIN;
          end else begin
            state <= S_PP_SEND;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgm_flash_writer.sv
module pgm_flash_writer
  import pgm_pkg::*;
#(
  parameter int         PAGE_BYTES = 256,
  parameter logic [7:0] GUARD_KEY  = 8'h30,
  localparam int        WORDS      = PAGE_BYTES / 4,
  localparam int        PTR_W      = $clog2(WORDS)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [7:0]  cmd_q,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi
);
  logic             cmd_go, cmd_inc, go_q;
  logic [23:0]      addr_q;
  logic [7:0]       byte_q, key_q;
  logic             mode_q;
  logic [PTR_W-1:0] fill_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [31:0]      rd_word;
  logic             wr_ok, buf_we, seq_done;

  assign wr_ok  = reg_we && !cmd_go;
  assign buf_we = wr_ok && (reg_sel_t'(reg_sel) == SEL_WORD);
  assign cmd_q  = {cmd_inc, 2'b00, cmd_go, 4'b0000};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_go   <= 1'b0;
      cmd_inc  <= 1'b0;
      go_q     <= 1'b0;
      addr_q   <= '0;
      byte_q   <= '0;
      key_q    <= '0;
      mode_q   <= 1'b0;
      fill_ptr <= '0;
    end else begin
      go_q <= 1'b0;
      if (wr_ok) begin
        case (reg_sel_t'(reg_sel))
          SEL_CMD: if (reg_wdata[GO_BIT] && key_q == GUARD_KEY) begin
            cmd_go  <= 1'b1;
            cmd_inc <= reg_wdata[INC_BIT];
            go_q    <= 1'b1;
          end
          SEL_A0:   addr_q[7:0]   <= reg_wdata[7:0];
          SEL_A1:   addr_q[15:8]  <= reg_wdata[7:0];
          SEL_A2:   addr_q[23:16] <= reg_wdata[7:0];
          SEL_BYTE: byte_q        <= reg_wdata[7:0];
          SEL_WORD: fill_ptr      <= fill_ptr + 1'b1;
          SEL_MODE: mode_q        <= reg_wdata[0];
          SEL_KEY:  key_q         <= reg_wdata[7:0];
          default: ;
        endcase
      end
      if (seq_done) begin
        cmd_go  <= 1'b0;
        cmd_inc <= 1'b0;
        if (mode_q)       fill_ptr <= '0;
        else if (cmd_inc) addr_q   <= addr_q + 1'b1;
      end
    end
  end

  pgm_page_buf #(.WORDS(WORDS), .DW(32)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (fill_ptr),
    .wdata (reg_wdata),
    .raddr (rd_ptr),
    .rdata (rd_word)
  );

  pgm_frame_seq #(.PAGE_BYTES(PAGE_BYTES)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .go          (go_q),
    .page_mode   (mode_q),
    .addr        (addr_q),
    .single_byte (byte_q),
    .ram_rdata   (rd_word),
    .ram_raddr   (rd_ptr),
    .done        (seq_done),
    .cs_n        (spi_cs_n),
    .sck         (spi_sck),
    .mosi        (spi_mosi)
  );
endmodule

// File: rtl/pgm_flash_writer_chk.sv
module pgm_flash_writer_chk #(
  parameter int         PTR_W     = 6,
  parameter logic [7:0] GUARD_KEY = 8'h30
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             inc,
  input logic             cs_n,
  input logic             sck,
  input logic             mosi,
  input logic [7:0]       key,
  input logic             mode,
  input logic [PTR_W-1:0] fill_ptr
);
  // R11
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sck);
  // R11
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst) sck |-> $stable(mosi));
  // R3
  cs_busy_chk: assert property (@(posedge clk) disable iff (rst) !cs_n |-> busy);
  // R3
  inc_pair_chk: assert property (@(posedge clk) disable iff (rst) inc |-> busy);
  // R4
  key_gate_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> key == GUARD_KEY);
  // R8
  ptr_clear_chk: assert property (@(posedge clk) disable iff (rst) ($fell(busy) && mode) |-> fill_ptr == '0);
  // R10
  busy_freeze_chk: assert property (@(posedge clk) disable iff (rst) busy |=> ($stable(mode) && $stable(key)));
endmodule

bind pgm_flash_writer pgm_flash_writer_chk #(.PTR_W(PTR_W), .GUARD_KEY(GUARD_KEY)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (cmd_go),
  .inc      (cmd_inc),
  .cs_n     (spi_cs_n),
  .sck      (spi_sck),
  .mosi     (spi_mosi),
  .key      (key_q),
  .mode     (mode_q),
  .fill_ptr (fill_ptr)
);

// File: tb/tb_pgm_flash_writer.sv
module tb_pgm_flash_writer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [7:0]  cmd_q;
  logic        spi_cs_n, spi_sck, spi_mosi;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pgm_flash_writer dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cmd_q(cmd_q), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi)
  );

  // behavioural model state
  int        m_addr = 0;
  bit [7:0]  m_byte = 0;
  bit        m_mode = 0;
  bit [7:0]  m_key = 0;
  bit [7:0]  m_buf [256];
  int        m_fptr = 0;
  int        got[$];
  int        exp_q[$];

  // wire monitor, compared every clock
  logic      prev_sck = 0, prev_cs = 1;
  bit [7:0]  sh = 0;
  int        nbits = 0;

  always @(negedge clk) begin
    if (!rst && !finished) begin
      vectors++;
      if (spi_sck && spi_cs_n) begin
        fails++;
        $display("FAIL R11: sck=%0b while cs_n=%0b (expected sck 0)", spi_sck, spi_cs_n);
      end
      if (!spi_cs_n && spi_sck && !prev_sck) begin
        sh = {sh[6:0], spi_mosi};
        nbits++;
        if (nbits == 8) begin
          got.push_back(int'(sh));
          nbits = 0;
        end
      end
      if (spi_cs_n && !prev_cs) begin
        got.push_back(-1);
        if (nbits != 0) begin
          fails++;
          $display("FAIL R11: frame ended with %0d stray bits (expected 0)", nbits);
          nbits = 0;
        end
      end
      prev_sck = spi_sck;
      prev_cs  = spi_cs_n;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic wr_raw(input int sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'(sel); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    case (sel)
      1: m_addr = (m_addr & 32'hFFFF00) | int'(d[7:0]);
      2: m_addr = (m_addr & 32'hFF00FF) | (int'(d[7:0]) << 8);
      3: m_addr = (m_addr & 32'h00FFFF) | (int'(d[7:0]) << 16);
      4: m_byte = d[7:0];
      5: begin
        for (int b = 0; b < 4; b++) m_buf[m_fptr*4+b] = d[b*8 +: 8];
        m_fptr = (m_fptr + 1) % 64;
      end
      6: m_mode = d[0];
      7: m_key = d[7:0];
      default: ;
    endcase
    wr_raw(sel, d);
  endtask

  task automatic build_exp();
    exp_q.push_back(8'h06); exp_q.push_back(-1);
    exp_q.push_back(8'h02);
    exp_q.push_back((m_addr >> 16) & 255);
    exp_q.push_back((m_addr >> 8) & 255);
    exp_q.push_back(m_addr & 255);
    if (m_mode) for (int i = 0; i < 256; i++) exp_q.push_back(int'(m_buf[i]));
    else exp_q.push_back(int'(m_byte));
    exp_q.push_back(-1);
  endtask

  task automatic compare(input string req);
    int bad = -1;
    if (got.size() == exp_q.size()) begin
      for (int i = 0; i < got.size(); i++) if (bad < 0 && got[i] != exp_q[i]) bad = i;
    end else bad = 0;
    vectors++;
    if (bad >= 0) begin
      fails++;
      if (got.size() != exp_q.size())
        $display("FAIL %s: frame length %0d expected %0d", req, got.size(), exp_q.size());
      else
        $display("FAIL %s: byte %0d actual 0x%0h expected 0x%0h", req, bad, got[bad], exp_q[bad]);
    end
    got.delete(); exp_q.delete();
  endtask

  task automatic wait_idle();
    int t = 0;
    while (cmd_q[4] && t < 20000) begin @(negedge clk); t++; end
    check(t < 20000, "R3 completion", t, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_op(input bit inc);
    if (m_mode) m_fptr = 0;
    else if (inc) m_addr = (m_addr + 1) & 32'hFFFFFF;
  endtask

  task automatic trig(input logic [7:0] v, input string req);
    if (v[4] && m_key == 8'h30) begin
      build_exp();
      wr_raw(0, {24'h0, v});
      repeat (2) @(negedge clk);
      check(cmd_q == (v & 8'h90), "R3 trigger view", cmd_q, v & 8'h90);
      wait_idle();
      check(cmd_q == 8'h00, "R3 self clear", cmd_q, 0);
      compare(req);
      finish_op(v[7]);
    end else begin
      wr_raw(0, {24'h0, v});
      repeat (60) @(negedge clk);
      check(cmd_q == 8'h00, req, cmd_q, 0);
      check(got.size() == 0, req, got.size(), 0);
      got.delete();
    end
  endtask

  task automatic fill_page(input int nwords, input int seed);
    for (int n = 0; n < nwords; n++) begin
      logic [31:0] w;
      for (int b = 0; b < 4; b++) w[b*8 +: 8] = 8'(((4*n + b) * 7 + seed) & 255);
      wr(5, w);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cmd_q == 8'h00, "R1 cmd", cmd_q, 0);
    check(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
    check(spi_sck == 1'b0 && spi_mosi == 1'b0, "R1 sck/mosi", {spi_sck, spi_mosi}, 0);

    // R4 key not loaded: trigger ignored
    wr(1, 32'h56); wr(2, 32'h34); wr(3, 32'h12); wr(4, 32'hA5);
    trig(8'h10, "R4 no key");
    wr(7, 32'h31);
    trig(8'h10, "R4 wrong key");
    wr(7, 32'h30);
    // R3 write without bit 4 has no effect
    trig(8'h80, "R3 no trigger bit");

    // R2 R5 R6 one-byte write
    trig(8'h10, "R2 R5 R6 single byte");
    // R9 no increment without bit 7: same address again
    wr(4, 32'h3C);
    trig(8'h10, "R9 no increment");
    // R9 increment chain
    wr(4, 32'h11);
    trig(8'h90, "R9 inc first");
    wr(4, 32'h22);
    trig(8'h90, "R9 inc second");
    // R9 wrap at top of address space
    wr(1, 32'hFF); wr(2, 32'hFF); wr(3, 32'hFF);
    wr(4, 32'h77);
    trig(8'h90, "R9 at top");
    wr(4, 32'h78);
    trig(8'h10, "R9 wrapped to zero");

    // R10 writes during busy ignored
    wr(1, 32'h9A); wr(2, 32'hBC); wr(3, 32'hDE); wr(4, 32'h5E);
    build_exp();
    wr_raw(0, 32'h10);
    repeat (6) @(negedge clk);
    wr_raw(1, 32'h00); wr_raw(4, 32'hEE); wr_raw(6, 32'h1); wr_raw(7, 32'h00);
    wait_idle();
    compare("R10 busy frame");
    trig(8'h10, "R10 state kept");

    // R7 page mode, little-endian packing
    wr(6, 32'h1);
    fill_page(64, 3);
    trig(8'h10, "R7 page");
    // R8 pointer restarted; R9 page with bit 7 keeps address
    fill_page(64, 91);
    trig(8'h90, "R8 R9 page refill");
    trig(8'h10, "R9 page address kept");
    // R8 wrap after 64 words
    fill_page(66, 200);
    trig(8'h10, "R8 wrap");

    // back to single mode
    wr(6, 32'h0);
    wr(4, 32'hC3);
    trig(8'h10, "R6 after page");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run did not complete (expected completion)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule